// File: doc/BRIEF.md
# I2C Paged Memory Target

This block is a target on a two-wire I2C bus that serves a 256-byte store, split into 16 pages of 16 bytes. The block samples SCL and SDA with its own system clock and finds START, repeated START and STOP conditions from those samples. It pulls SDA low to acknowledge and to send data bits. A host reaches the store with byte writes, page writes, selective reads and current-address reads.

Incoming write data is held in a one-page staging buffer. That buffer is copied into the store only after the host sends STOP. The copy takes a timed busy window of `BUSY_CYCLES` clocks. During that window the block does not answer its own address, so a host can poll to find out when the window has ended.

Two mechanisms can block a commit. One is a protect pin, which guards the whole store. The other is a lock flag that guards only the lower half. The flag is set by a bus command and stays set until reset.

Top module: `i2c_paged_store`

## Requirements
- R1: The target answers the 7-bit address made of binary 1010 followed by `strap[2:0]`. Bit 0 of the address byte selects the direction (0 = write, 1 = read). A byte carrying any other address, including one with the right prefix but other strap levels, is not acknowledged.
- R2: A byte write works as follows. The host sends START, the address byte, a memory address byte and one data byte. Each of these three bytes is acknowledged. After STOP and the busy window, the data byte can be read back from that memory address.
- R3: Written bytes reach the store only after a STOP. If a repeated START comes before that STOP, the staged bytes are dropped and no busy window starts.
- R4: After a STOP that ends an accepted write, a busy window of `BUSY_CYCLES` clocks runs. During the window, address bytes for both reads and writes get no acknowledge. After the window ends, they are acknowledged again.
- R5: In the memory address byte, bits [7:4] select the page and bits [3:0] select the byte inside it. The byte pointer advances after each data byte and wraps from offset 15 to offset 0 of the same page, so later bytes overwrite earlier ones.
- R6: When the busy window ends, only the page offsets that received a byte are updated. All other bytes keep their old values.
- R7: If `wp_lock` is 1 when the STOP arrives, the data bytes are still acknowledged. Nothing is stored and no busy window starts.
- R8: A write-direction address byte of binary 0110 followed by `strap[2:0]` is acknowledged and sets the lower-half lock. While the lock is set, a write to 0x00–0x7F is acknowledged but not stored and starts no busy window. Addresses 0x80–0xFF stay writable, and the lock remains set until reset.
- R9: After reset every byte reads 0xFF, the lock is clear and SDA is released (`sda_drive_low` = 0).
- R10: A selective read is a write of the memory address, then a repeated START with a read address byte. Sequential reads advance the pointer from 0xFF to 0x00. A current-address read starts at the byte after the last one read. A read ends when the host answers NACK. `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| strap | input | 3 | Low three bits of the target address |
| wp_lock | input | 1 | 1 blocks commits to the whole store |
| sda_drive_low | output | 1 | 1 pulls the SDA line low |

## Verification
The acknowledge decision on an address byte and the busy window that follows a commit can overlap. A host that addresses the target right after its STOP has to be refused. The same host has to be accepted once the window has run out. The bench polls for a read and for a write straight after a STOP and expects NACK. It then waits past the window and expects ACK, and reads the data back to confirm that the commit happened when the window ended. Protected writes are the counterpart: acknowledged data, an immediate ACK on the next poll, and an unchanged byte. Those results show that protection stops the busy window as well as the store.

// File: rtl/i2c_paged_store.sv
module i2c_paged_store #(
  parameter int        BUSY_CYCLES = 500000,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter logic [3:0] LOCK_PREFIX = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  input  logic       wp_lock,
  output logic       sda_drive_low
);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam int PAGE  = 16;
  localparam int DEPTH = 256;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_MEM, S_WR, S_RD, S_HACK} st_t;

  logic [2:0] scl_sy, sda_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  logic scl_s, scl_p, sda_s, sda_p;
  assign scl_s = scl_sy[1];
  assign scl_p = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_p = sda_sy[2];

  logic scl_rise, scl_fall, start_seen, stop_seen;
  assign scl_rise   = scl_s & ~scl_p;
  assign scl_fall   = ~scl_s & scl_p;
  assign start_seen = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_seen  = scl_s & scl_p & ~sda_p & sda_s;

  st_t               st, st_nx;
  logic [3:0]        bitc;
  logic              in_ack, host_ack;
  logic [7:0]        sh, tx, ptr;
  logic [3:0]        page;
  logic [PAGE-1:0]   vld;
  logic              busy, lock_lo;
  logic [BW-1:0]     bcnt;
  logic [7:0]        pgbuf [PAGE];
  logic [7:0]        mem   [DEPTH];

  logic dev_hit, lock_hit, guard, commit, wr_en;
  assign dev_hit  = sh[7:1] == {DEV_PREFIX, strap};
  assign lock_hit = (sh[7:1] == {LOCK_PREFIX, strap}) && !sh[0];
  assign guard    = wp_lock | (lock_lo & ~page[3]);
  assign commit   = busy && (bcnt == '0);
  assign wr_en    = (st == S_WR) && scl_fall && !in_ack && (bitc == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; st_nx <= S_IDLE; bitc <= '0; in_ack <= 1'b0; host_ack <= 1'b0;
      sh <= '0; tx <= '0; ptr <= '0; page <= '0; vld <= '0;
      busy <= 1'b0; lock_lo <= 1'b0; bcnt <= '0; sda_drive_low <= 1'b0;
    end else begin
      if (commit) begin
        busy <= 1'b0;
        vld  <= '0;
      end else if (busy) begin
        bcnt <= bcnt - 1'b1;
      end

      if (start_seen) begin
        st <= S_DEV; bitc <= '0; in_ack <= 1'b0; sda_drive_low <= 1'b0;
        if (!busy) vld <= '0;
      end else if (stop_seen) begin
        st <= S_IDLE; in_ack <= 1'b0; sda_drive_low <= 1'b0;
        if (!busy) begin
          if (|vld && !guard) begin
            busy <= 1'b1;
            bcnt <= BW'(BUSY_CYCLES - 1);
          end else begin
            vld <= '0;
          end
        end
      end else begin
        case (st)
          S_DEV, S_MEM, S_WR: begin
            if (scl_rise && !in_ack) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              bitc   <= '0;
              st     <= st_nx;
              if (st_nx == S_RD) begin
                tx            <= mem[ptr];
                sda_drive_low <= ~mem[ptr][7];
              end else begin
                sda_drive_low <= 1'b0;
              end
            end else if (scl_fall && bitc == 4'd8) begin
              if (st == S_DEV) begin
                if (!busy && dev_hit) begin
                  in_ack <= 1'b1; sda_drive_low <= 1'b1;
                  st_nx  <= sh[0] ? S_RD : S_MEM;
                end else if (!busy && lock_hit) begin
                  in_ack <= 1'b1; sda_drive_low <= 1'b1;
                  lock_lo <= 1'b1; st_nx <= S_IDLE;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_MEM) begin
                in_ack <= 1'b1; sda_drive_low <= 1'b1;
                ptr <= sh; page <= sh[7:4]; st_nx <= S_WR;
              end else begin
                in_ack <= 1'b1; sda_drive_low <= 1'b1;
                vld[ptr[3:0]] <= 1'b1;
                ptr[3:0]      <= ptr[3:0] + 4'd1;
              end
            end
          end
          S_RD: begin
            if (scl_rise) begin
              bitc <= bitc + 4'd1;
            end else if (scl_fall) begin
              if (bitc == 4'd8) begin
                sda_drive_low <= 1'b0;
                ptr <= ptr + 8'd1;
                st  <= S_HACK;
              end else begin
                tx            <= {tx[6:0], 1'b0};
                sda_drive_low <= ~tx[6];
              end
            end
          end
          S_HACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx <= mem[ptr]; sda_drive_low <= ~mem[ptr][7];
                bitc <= '0; st <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (wr_en) pgbuf[ptr[3:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (vld[i]) mem[{page, 4'(i)}] <= pgbuf[i];
    end
endmodule

// File: rtl/i2c_paged_store_chk.sv
module i2c_paged_store_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_drive_low,
  input logic busy,
  input logic stop_seen,
  input logic wp_lock,
  input logic lock_lo
);
  p_quiet_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_drive_low);

  p_commit_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));

  p_pin_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_lock));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lo |=> lock_lo);

  p_sda_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !$past(scl_s));
endmodule

bind i2c_paged_store i2c_paged_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_drive_low(sda_drive_low),
  .busy(busy), .stop_seen(stop_seen), .wp_lock(wp_lock), .lock_lo(lock_lo)
);

// File: tb/i2c_paged_store_tb.sv
module i2c_paged_store_tb;
  localparam int BUSY = 2000;
  localparam int H    = 20;
  localparam logic [7:0] DEVW = 8'hAA, DEVR = 8'hAB, LOCKW = 8'h6A;

  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_drive_low;
  wire  sda_bus = sda_h & ~sda_drive_low;

  int n_chk = 0, n_bad = 0, hi_moves = 0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #5 clk = ~clk;

  i2c_paged_store #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_bus),
    .strap(strap), .wp_lock(wp), .sda_drive_low(sda_drive_low));

  logic prev_drv = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_h && (sda_drive_low !== prev_drv)) hi_moves++;
    prev_drv <= sda_drive_low;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    tick(4); sda_h = b; tick(H - 4);
    scl_h = 1'b1; tick(H); scl_h = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(4); sda_h = 1'b1; tick(H - 4);
    scl_h = 1'b1; tick(H / 2); b = sda_bus; tick(H / 2); scl_h = 1'b0;
  endtask

  task automatic i2c_start();
    sda_h = 1'b1; tick(H); scl_h = 1'b1; tick(H);
    sda_h = 1'b0; tick(H); scl_h = 1'b0; tick(H);
  endtask

  task automatic i2c_stop();
    sda_h = 1'b0; tick(H); scl_h = 1'b1; tick(H); sda_h = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input string req);
    logic ack;
    i2c_start();
    send_byte(DEVW, ack); chk(req, 16'(ack), 16'd1);
    send_byte(a, ack);    chk(req, 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk(req, 16'(ack), 16'd1);
    end
    i2c_stop();
  endtask

  task automatic read_at(input logic [7:0] a, input int n);
    logic ack;
    i2c_start();
    send_byte(DEVW, ack);
    send_byte(a, ack);
    i2c_start();
    send_byte(DEVR, ack);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic poll(input logic [7:0] dev, output logic ack);
    i2c_start();
    send_byte(dev, ack);
    i2c_stop();
  endtask

  task automatic wait_busy();
    tick(BUSY + 100);
  endtask

  task automatic t_reset();
    chk("R9 sda released", 16'(sda_drive_low), 16'd0);
    read_at(8'h05, 1);
    chk("R9 erased byte", 16'(rbuf[0]), 16'hFF);
  endtask

  task automatic t_byte_write();
    logic ack;
    wbuf[0] = 8'h3C;
    do_write(8'h00, 1, "R2 byte write ack");
    poll(DEVW, ack); chk("R4 write poll while busy", 16'(ack), 16'd0);
    poll(DEVR, ack); chk("R4 read poll while busy", 16'(ack), 16'd0);
    wait_busy();
    poll(DEVW, ack); chk("R4 poll after window", 16'(ack), 16'd1);
    read_at(8'h00, 1);
    chk("R2 byte readback", 16'(rbuf[0]), 16'h3C);
  endtask

  task automatic t_address();
    logic ack;
    poll(8'hA6, ack); chk("R1 wrong strap", 16'(ack), 16'd0);
    poll(8'hBA, ack); chk("R1 wrong prefix", 16'(ack), 16'd0);
    poll(DEVW, ack);  chk("R1 own address", 16'(ack), 16'd1);
  endtask

  task automatic t_abandon();
    logic ack;
    i2c_start();
    send_byte(DEVW, ack); send_byte(8'h40, ack); send_byte(8'h33, ack);
    chk("R3 data ack", 16'(ack), 16'd1);
    i2c_start();
    send_byte(DEVW, ack); chk("R3 no busy before stop", 16'(ack), 16'd1);
    send_byte(8'h40, ack);
    i2c_start();
    send_byte(DEVR, ack);
    recv_byte(1'b0, rbuf[0]);
    i2c_stop();
    chk("R3 not stored before stop", 16'(rbuf[0]), 16'hFF);
    poll(DEVW, ack); chk("R3 dropped bytes start no window", 16'(ack), 16'd1);
    read_at(8'h40, 1);
    chk("R3 dropped bytes absent", 16'(rbuf[0]), 16'hFF);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 18; k++) wbuf[k] = 8'h40 + 8'(k);
    do_write(8'h2E, 18, "R5 page write ack");
    wait_busy();
    read_at(8'h20, 16);
    for (int j = 0; j < 14; j++) chk("R5 wrapped byte", 16'(rbuf[j]), 16'(8'h42 + 8'(j)));
    chk("R5 overwrite offset 14", 16'(rbuf[14]), 16'h50);
    chk("R5 overwrite offset 15", 16'(rbuf[15]), 16'h51);
  endtask

  task automatic t_partial();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    do_write(8'h65, 3, "R6 partial write ack");
    wait_busy();
    read_at(8'h63, 6);
    chk("R6 untouched 0x63", 16'(rbuf[0]), 16'hFF);
    chk("R6 untouched 0x64", 16'(rbuf[1]), 16'hFF);
    chk("R6 byte 0x65", 16'(rbuf[2]), 16'hA1);
    chk("R6 byte 0x66", 16'(rbuf[3]), 16'hA2);
    chk("R6 byte 0x67", 16'(rbuf[4]), 16'hA3);
    chk("R6 untouched 0x68", 16'(rbuf[5]), 16'hFF);
  endtask

  task automatic t_reads();
    logic ack;
    wbuf[0] = 8'hA5;
    do_write(8'hFF, 1, "R10 setup write");
    wait_busy();
    read_at(8'hFF, 3);
    chk("R10 read 0xFF", 16'(rbuf[0]), 16'hA5);
    chk("R10 wrap to 0x00", 16'(rbuf[1]), 16'h3C);
    chk("R10 then 0x01", 16'(rbuf[2]), 16'hFF);
    read_at(8'h20, 1);
    i2c_start();
    send_byte(DEVR, ack); chk("R10 current read ack", 16'(ack), 16'd1);
    recv_byte(1'b0, rbuf[0]);
    i2c_stop();
    chk("R10 current address read", 16'(rbuf[0]), 16'h43);
  endtask

  task automatic t_pin();
    logic ack;
    wp = 1'b1;
    wbuf[0] = 8'h11;
    do_write(8'h90, 1, "R7 acked under pin");
    poll(DEVW, ack); chk("R7 no busy window", 16'(ack), 16'd1);
    wp = 1'b0;
    read_at(8'h90, 1);
    chk("R7 byte unchanged", 16'(rbuf[0]), 16'hFF);
  endtask

  task automatic t_lock();
    logic ack;
    poll(LOCKW, ack); chk("R8 lock command ack", 16'(ack), 16'd1);
    wbuf[0] = 8'h22;
    do_write(8'h10, 1, "R8 lower write ack");
    poll(DEVW, ack); chk("R8 lower write no window", 16'(ack), 16'd1);
    read_at(8'h10, 1);
    chk("R8 lower byte unchanged", 16'(rbuf[0]), 16'hFF);
    wbuf[0] = 8'h44;
    do_write(8'h80, 1, "R8 upper write ack");
    poll(DEVW, ack); chk("R8 upper write busy", 16'(ack), 16'd0);
    wait_busy();
    read_at(8'h80, 1);
    chk("R8 upper byte stored", 16'(rbuf[0]), 16'h44);
    wbuf[0] = 8'h55;
    do_write(8'h7F, 1, "R8 lock still set ack");
    wait_busy();
    read_at(8'h7F, 1);
    chk("R8 lock sticky", 16'(rbuf[0]), 16'hFF);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_byte_write();
    t_address();
    t_abandon();
    t_wrap();
    t_partial();
    t_reads();
    t_pin();
    t_lock();
    chk("R10 sda steady while SCL high", 16'(hi_moves), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule